// File: doc/BRIEF.md
# Dual-Strobe Burst Address Counter

This block produces the word address for a four-beat burst into a synchronous memory array. A burst starts when one of two active-low address strobes is seen at a rising clock edge. One strobe comes from the processor and the other from a cache controller. The full input address is then captured into a register. After that, the two least significant bits step through four beats under an active-low advance input. The upper bits keep the captured value. A beat index counts from zero and wraps. It is combined with the captured start bits to form the low address bits.

The order of the beats is chosen by a static order input and is registered each cycle. A high value gives interleaved order, where beat n is start XOR n. A low value gives linear order, where beat n is (start + n) mod 4. When the order input is undriven in simulation, the block uses interleaved order. The processor strobe wins when both strobes are low at the same edge. The processor strobe is also ignored when the first select input is high. A two-bit action code reports what the last edge did: a load, a step or a hold.

Top module: `dual_strobe_burst_ctr`

## Requirements
- R1: A synchronous reset sets the address output to zero, sets the action code to hold (00) and sets the order to interleaved.
- R2: On an edge where a strobe is honoured and all three selects are active (sel1_n low, sel2 high, sel3_n low), the address output equals the sampled input address from the next cycle on.
- R3: When both strobes are low on the same edge and all selects are active, the action code becomes 10 (processor load). A load from the controller strobe alone gives 11.
- R4: While sel1_n is high, the processor strobe has no effect. With the controller strobe high, the edge is then treated as having no strobe, so it steps or holds depending on the advance input.
- R5: If an honoured strobe is present but any select is inactive, nothing is captured, the address does not change, and the action code becomes 00.
- R6: In linear order (order_sel sampled low), each step adds 1 modulo 4 to the two low bits. For example, a start of 01 gives 01, 10, 11, 00.
- R7: In interleaved order (order_sel sampled high), beat n is the start XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R8: With no strobe present, an edge with adv_n low steps the burst and sets the action code to 01. An edge with adv_n high holds the address and sets the action code to 00.
- R9: Only the two low bits change during a burst. After four steps the low bits return to the start value.
- R10: order_sel is registered, so a change in it affects the address output from the cycle after the edge that samples it, even while the burst holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Word address presented with a strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Select 1, active low; also masks the processor strobe |
| sel2 | input | 1 | Select 2, active high |
| sel3_n | input | 1 | Select 3, active low |
| order_sel | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_o | output | ADDR_W | Current array word address |
| action_o | output | 2 | Last edge: 00 hold, 01 step, 10 processor load, 11 controller load |

## Verification
The assertions assume that every control input is a known 0 or 1 at each sampled edge. The stepping checks also assume that order_sel is stable across the two cycles being compared. When the order changes, the stepping properties are dropped instead of being given an expected value. The stimulus drives all inputs one half-cycle away from the sampling edge and never leaves them undriven. Random traffic flips the order input only occasionally, so most steps are compared under a constant order. The directed cases cover an order change during a hold, both strobes low together, and each select going inactive while a strobe is present.

// File: rtl/dual_strobe_burst_ctr.sv
module dual_strobe_burst_ctr #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        action_o
);
  localparam logic [1:0] ACT_HOLD   = 2'b00;
  localparam logic [1:0] ACT_STEP   = 2'b01;
  localparam logic [1:0] ACT_LOAD_P = 2'b10;
  localparam logic [1:0] ACT_LOAD_C = 2'b11;

  logic [ADDR_W-1:2] base_q;
  logic [1:0]        start_q;
  logic [1:0]        beat_q;
  logic [1:0]        act_q;
  logic              ilv_q;

  logic selected, proc_hit, any_stb;
  logic [1:0] low_bits;

  assign selected = ~sel1_n & sel2 & ~sel3_n;
  assign proc_hit = ~proc_stb_n & ~sel1_n;
  assign any_stb  = proc_hit | ~ctrl_stb_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
      act_q   <= ACT_HOLD;
      ilv_q   <= 1'b1;
    end else begin
      ilv_q <= (order_sel !== 1'b0);
      if (any_stb) begin
        if (selected) begin
          base_q  <= addr_in[ADDR_W-1:2];
          start_q <= addr_in[1:0];
          beat_q  <= '0;
          act_q   <= proc_hit ? ACT_LOAD_P : ACT_LOAD_C;
        end else begin
          act_q <= ACT_HOLD;
        end
      end else if (!adv_n) begin
        beat_q <= beat_q + 2'd1;
        act_q  <= ACT_STEP;
      end else begin
        act_q <= ACT_HOLD;
      end
    end
  end

  assign low_bits = ilv_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_o   = {base_q, low_bits};
  assign action_o = act_q;
endmodule

module burst_ctr_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        action_o,
  input logic              ilv_q
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (rst)
    (past_ok && action_o[1]) |-> addr_o == $past(addr_in));

  a_r3_proc_first: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && !ctrl_stb_n && !sel1_n && sel2 && !sel3_n) |=> action_o == 2'b10);

  a_r4_sel1_masks_proc: assert property (@(posedge clk) disable iff (rst)
    sel1_n |=> action_o != 2'b10);

  a_r5_need_all_selects: assert property (@(posedge clk) disable iff (rst)
    !(!sel1_n && sel2 && !sel3_n) |=> !action_o[1]);

  a_r8_hold_keeps_addr: assert property (@(posedge clk) disable iff (rst)
    (past_ok && action_o == 2'b00 && $stable(ilv_q)) |-> $stable(addr_o));

  a_r9_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !action_o[1]) |-> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  a_r6_linear_step: assert property (@(posedge clk) disable iff (rst)
    (past_ok && action_o == 2'b01 && !ilv_q && $stable(ilv_q))
      |-> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);
endmodule

bind dual_strobe_burst_ctr burst_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr_in(addr_in), .proc_stb_n(proc_stb_n),
  .ctrl_stb_n(ctrl_stb_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
  .addr_o(addr_o), .action_o(action_o), .ilv_q(ilv_q)
);

// File: tb/tb_dual_strobe_burst_ctr.sv
`timescale 1ns/1ps
module tb_dual_strobe_burst_ctr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] addr_in = '0;
  logic proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1;
  logic s1_n = 1'b0, s2 = 1'b1, s3_n = 1'b0, ord = 1'b1;
  logic [W-1:0] addr_o;
  logic [1:0] action_o;

  always #2.5 clk = ~clk;

  dual_strobe_burst_ctr #(.ADDR_W(W)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_stb_n(proc_n),
    .ctrl_stb_n(ctrl_n), .adv_n(adv_n), .sel1_n(s1_n), .sel2(s2),
    .sel3_n(s3_n), .order_sel(ord), .addr_o(addr_o), .action_o(action_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:2] m_base;
  logic [1:0] m_start, m_beat, m_act;
  logic m_ilv;
  string m_tag;

  function automatic logic [W-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_ilv ? (m_start ^ m_beat) : (m_start + m_beat);
    return {m_base, lo};
  endfunction

  task automatic model_edge();
    logic sel_ok, p_hit, any;
    if (rst) begin
      m_base = '0; m_start = '0; m_beat = '0; m_act = 2'b00; m_ilv = 1'b1; m_tag = "R1";
      return;
    end
    sel_ok = !s1_n && s2 && !s3_n;
    p_hit  = !proc_n && !s1_n;
    any    = p_hit || !ctrl_n;
    if (any && sel_ok) begin
      m_base = addr_in[W-1:2]; m_start = addr_in[1:0]; m_beat = '0;
      m_act = p_hit ? 2'b10 : 2'b11; m_tag = p_hit ? "R3" : "R2";
    end else if (any) begin
      m_act = 2'b00; m_tag = "R5";
    end else if (!adv_n) begin
      m_beat = m_beat + 2'd1; m_act = 2'b01; m_tag = ord ? "R7" : "R6";
    end else begin
      m_act = 2'b00; m_tag = "R8";
    end
    m_ilv = ord;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (addr_o !== exp_addr() || action_o !== m_act) begin
      fails++;
      $display("FAIL %s: addr=%h act=%0d expected addr=%h act=%0d",
               (tag == "") ? m_tag : tag, addr_o, action_o, exp_addr(), m_act);
    end
  endtask

  task automatic drv(input logic p, input logic c, input logic a,
                     input logic [W-1:0] ad);
    proc_n = p; ctrl_n = c; adv_n = a; addr_in = ad;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    step("R1"); step("R1");
    rst = 1'b0;
    // R7 interleaved from start 01, then wrap (R9)
    drv(1, 0, 1, 18'h2A5D5); step("R2");
    drv(1, 1, 0, '0);
    step("R7"); step("R7"); step("R7"); step("R9");
    // R8 hold, then R10 order change during hold
    drv(1, 1, 1, '0); step("R8");
    ord = 1'b0; step("R10"); step("R10");
    // R6 linear from start 01
    drv(0, 1, 1, 18'h10001); step("R2");
    drv(1, 1, 0, '0);
    step("R6"); step("R6"); step("R6"); step("R9");
    // R3 both strobes low
    drv(0, 0, 1, 18'h3FFFE); step("R3");
    // R4 sel1 high masks processor strobe: steps instead
    s1_n = 1'b1; drv(0, 1, 0, 18'h00003); step("R4");
    // R5 controller strobe with sel1 high: no capture
    drv(1, 0, 0, 18'h00003); step("R5");
    s1_n = 1'b0; s2 = 1'b0; drv(0, 1, 0, 18'h12345); step("R5");
    s2 = 1'b1; s3_n = 1'b1; drv(1, 0, 0, 18'h12345); step("R5");
    s3_n = 1'b0;
    // controller-only load reports 11
    drv(1, 0, 1, 18'h0ABC2); step("R3");
    for (int i = 0; i < 600; i++) begin
      proc_n = ($urandom % 5) != 0;
      ctrl_n = ($urandom % 5) != 0;
      adv_n  = ($urandom % 5) < 2;
      s1_n   = ($urandom % 8) == 0;
      s2     = ($urandom % 10) != 0;
      s3_n   = ($urandom % 10) == 0;
      if (($urandom % 30) == 0) ord = ~ord;
      addr_in = W'($urandom);
      step("");
    end
    finish_run();
  end
endmodule